// File: doc/BRIEF.md
# PHY Test-Port Configuration Register Slave

This block sits on the PHY side of a narrow two-word test-control port. The host does not drive an address bus. It places a word on a shared test word input and toggles a strobe line. When bit 16 of the word is set, the word names a register. When bit 16 is clear, the word carries the value for the register named last. Each configuration write therefore takes two strobed phases: first the index, then the byte.

The block holds a bank of byte-wide timing and PLL configuration registers. The clock lane, each of up to four data lanes and the PLL all take their settings from this bank. A combinational read port lets the rest of the PHY read any entry. The strobe and the clear line arrive from another clock domain, so both pass through synchronisers first. A phase is captured on the falling edge of the synchronised strobe. While the synchronised clear is high, every register is zeroed and the phase logic returns to waiting for an index.

Top module: `tport_cfg_slave`

## Requirements
- R1: After reset every register in the bank reads 0, and no index is pending, so a value phase before any index phase writes nothing.
- R2: A phase whose word has bit 16 set takes bits 6:0 as the register index and leaves the bank unchanged.
- R3: A value phase that follows an index phase writes bits 7:0 of the word into the indexed register. The new value is readable after the third rising clock edge following the strobe fall, and not after the second.
- R4: A value phase with no pending index leaves every register unchanged.
- R5: A pending index allows exactly one write. A second value phase without a new index phase writes nothing.
- R6: A phase is captured only on the strobe's falling edge. While the strobe is high or stays low, nothing is written.
- R7: While the synchronised clear is high, every register reads 0 and any pending index is dropped. A value phase after the clear, with no new index phase, writes nothing.
- R8: When two index phases occur back to back, the later index receives the next value.
- R9: rd_data shows the register selected by rd_addr in the same cycle, with no clock edge between them.
- R10: In an index word, bits 15:7 are ignored. In a value word, bits 15:8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_strobe | input | 1 | Phase strobe, asynchronous; the falling edge captures the word |
| ctl_clear | input | 1 | Clear request, asynchronous; level-sensitive after synchronising |
| tst_word | input | 17 | Bit 16 is the index flag; bits 6:0 are the index, bits 7:0 the value |
| rd_addr | input | 7 | Readback register select |
| rd_data | output | 8 | Content of the selected register |

## Verification
Each scenario releases the strobe or changes the clear line on a falling clock edge, then counts rising edges before it samples. A write appears after the third rising edge: two for the synchroniser and one for the bank. A clear takes effect after the same three edges. The latency scenario samples once after the second edge, where the old value must still show, and again after the third, where the new value must show. Readback involves no register, so the bench changes rd_addr and samples one nanosecond later within the same low clock phase. After each scenario, all 128 entries are compared against a model kept in the bench.

// File: rtl/tport_cfg_slave.sv
module tport_cfg_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int FLAG_BIT    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_strobe,
  input  logic                ctl_clear,
  input  logic [FLAG_BIT:0]   tst_word,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SYNC_STAGES-1:0] strb_sync;
  logic [SYNC_STAGES-1:0] clr_pipe;
  logic                   strb_d;
  logic                   armed;
  logic [ADDR_W-1:0]      addr_q;
  logic [DATA_W-1:0]      bank [DEPTH];

  wire strb_now  = strb_sync[SYNC_STAGES-1];
  wire strb_fall = strb_d & ~strb_now;
  wire clr_sync  = clr_pipe[SYNC_STAGES-1];
  wire flag      = tst_word[FLAG_BIT];
  wire [DATA_W-1:0] payload = tst_word[DATA_W-1:0];
  wire [ADDR_W-1:0] index   = tst_word[ADDR_W-1:0];
  wire unused_hi = ^tst_word[FLAG_BIT-1:DATA_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      strb_sync <= '0;
      clr_pipe  <= '0;
      strb_d    <= 1'b0;
    end else begin
      strb_sync <= {strb_sync[SYNC_STAGES-2:0], ctl_strobe};
      clr_pipe  <= {clr_pipe[SYNC_STAGES-2:0], ctl_clear};
      strb_d    <= strb_now;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed  <= 1'b0;
      addr_q <= '0;
    end else if (clr_sync) begin
      armed  <= 1'b0;
      addr_q <= '0;
    end else if (strb_fall) begin
      if (flag) begin
        armed  <= 1'b1;
        addr_q <= index;
      end else begin
        armed  <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else if (clr_sync) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else if (strb_fall && !flag && armed) begin
      bank[addr_q] <= payload;
    end

  assign rd_data = bank[rd_addr];
endmodule

// File: rtl/tport_cfg_slave_chk.sv
module tport_cfg_slave_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              strb_fall,
  input logic              clr_sync,
  input logic              flag,
  input logic              armed,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] payload,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  AST_INDEX_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && !clr_sync && flag) |=> armed); // R2

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && !clr_sync && !flag && armed && rd_addr == addr_q)
    |=> (rd_addr != $past(rd_addr)) || (rd_data == $past(payload))); // R3

  AST_ORPHAN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && !clr_sync && !flag && !armed)
    |=> !armed && ((rd_addr != $past(rd_addr)) || $stable(rd_data))); // R4

  AST_ONE_WRITE_PER_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_fall && !clr_sync && !flag) |=> !armed); // R5

  AST_HOLD_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_fall && !clr_sync)
    |=> (rd_addr != $past(rd_addr)) || $stable(rd_data)); // R6

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sync |=> (rd_data == '0) && !armed); // R7
endmodule

bind tport_cfg_slave tport_cfg_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .strb_fall(strb_fall), .clr_sync(clr_sync),
  .flag(flag), .armed(armed), .addr_q(addr_q), .payload(payload),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_tport_cfg_slave.sv
`timescale 1ns/1ps
module tb_tport_cfg_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_strobe = 1'b0;
  logic        ctl_clear = 1'b0;
  logic [16:0] tst_word = '0;
  logic [6:0]  rd_addr = '0;
  logic [7:0]  rd_data;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [128];

  always #2.5 clk = ~clk;

  tport_cfg_slave dut (
    .clk(clk), .rst_n(rst_n), .ctl_strobe(ctl_strobe), .ctl_clear(ctl_clear),
    .tst_word(tst_word), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic scan_all(input string tag);
    int bad = -1;
    logic [7:0] g = '0;
    for (int a = 0; a < 128; a++) begin
      @(negedge clk);
      rd_addr = 7'(a);
      #1;
      if (rd_data !== model[a] && bad < 0) begin bad = a; g = rd_data; end
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s: reg %0d got %02h expected %02h", tag, bad, g, model[bad]);
    end
  endtask

  task automatic phase(input logic [16:0] w);
    @(negedge clk);
    tst_word = w;
    ctl_strobe = 1'b1;
    repeat (3) @(negedge clk);
    ctl_strobe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_at(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic t_reset;
    scan_all("R1 bank zero after reset");
  endtask

  task automatic t_orphan;
    phase(17'h0_005A);
    scan_all("R4 value phase with no index ignored");
    phase(17'h0_0066);
    scan_all("R1 no index pending after reset");
  endtask

  task automatic t_latency;
    logic [7:0] v;
    phase(17'h1_0003);
    scan_all("R2 index phase leaves bank unchanged");
    @(negedge clk);
    rd_addr = 7'd3;
    tst_word = 17'h0_00A5;
    ctl_strobe = 1'b1;
    repeat (3) @(negedge clk);
    ctl_strobe = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 old value after second edge", rd_data, 8'h00);
    @(posedge clk);
    @(negedge clk);
    chk("R3 new value after third edge", rd_data, 8'hA5);
    model[3] = 8'hA5;
    read_at(7'd3, v);
    chk("R3 written value holds", v, 8'hA5);
  endtask

  task automatic t_single_use;
    phase(17'h0_0011);
    scan_all("R5 second value phase without index ignored");
  endtask

  task automatic t_last_index;
    phase(17'h1_000A);
    phase(17'h1_0014);
    phase(17'h0_0077);
    model[20] = 8'h77;
    scan_all("R8 later index receives value");
  endtask

  task automatic t_rise_only;
    logic [7:0] v;
    phase(17'h1_0021);
    @(negedge clk);
    rd_addr = 7'd33;
    tst_word = 17'h0_00C9;
    ctl_strobe = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 strobe high writes nothing", rd_data, 8'h00);
    ctl_strobe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6 falling edge writes", rd_data, 8'hC9);
    model[33] = 8'hC9;
    repeat (10) @(negedge clk);
    read_at(7'd33, v);
    chk("R6 steady low strobe changes nothing", v, 8'hC9);
  endtask

  task automatic t_field_mask;
    phase(17'h1_FF85);
    phase(17'h0_C33C);
    model[5] = 8'h3C;
    scan_all("R10 upper index and value bits ignored");
  endtask

  task automatic t_comb_read;
    @(negedge clk);
    rd_addr = 7'd20;
    #1;
    chk("R9 readback same cycle reg20", rd_data, 8'h77);
    rd_addr = 7'd5;
    #1;
    chk("R9 readback same cycle reg5", rd_data, 8'h3C);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    phase(17'h1_0040);
    @(negedge clk);
    ctl_clear = 1'b1;
    repeat (3) @(posedge clk);
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    scan_all("R7 bank zero while clear high");
    @(negedge clk);
    ctl_clear = 1'b0;
    repeat (4) @(negedge clk);
    phase(17'h0_00EE);
    scan_all("R7 pending index dropped by clear");
    phase(17'h1_0040);
    phase(17'h0_0042);
    read_at(7'd64, v);
    chk("R7 write after clear works", v, 8'h42);
    model[64] = 8'h42;
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int a = 0; a < 128; a++) model[a] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_orphan();
    t_latency();
    t_single_use();
    t_last_index();
    t_rise_only();
    t_field_mask();
    t_comb_read();
    t_clear();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule